// File: doc/BRIEF.md
# PLL Lock Detector

This block judges whether a phase-locked loop has settled. A fast sampling clock watches the up and down outputs of the phase-frequency detector. For each reference period, the block measures how long either pulse was active, in sampling-clock ticks. The end of each reference period is marked by a single-tick strobe. A period whose measured phase error stays under a fixed time limit is a good period. The block raises its lock flag once a run of consecutive good periods reaches a selectable length.

The lock flag also drives an RF output enable. When muting is enabled, the enable stays off until the loop is locked. When muting is disabled, the enable depends only on the power state. A power-down input clears the whole detector and forces the enable off at once.

Top module: `lockdet_top`

## Requirements
- R1: In each reference window, every sampling tick where pfd_up or pfd_dn is high is counted; the window includes the tick on which ref_strobe is high. The window is good when ticks × CLK_PS < ERR_PS. With the defaults (CLK_PS = 4000, ERR_PS = 15000), three ticks or fewer is good and four ticks or more is bad.
- R2: With prec_sel = 0, lock_det rises after the clock edge that samples the strobe of the third good window in a row. lock_det changes only on strobe edges, power-down edges or reset.
- R3: With prec_sel = 1, lock_det rises after the edge that samples the strobe of the fifth good window in a row.
- R4: A bad window clears the run length and drops lock_det at the edge that samples its strobe. A complete new run is then needed to lock again.
- R5: The run length saturates at its target value. Any number of further good windows keeps lock_det high, with no wraparound.
- R6: While pwr_dn is high, the lock flag, the run length and the partial tick count are held cleared, and strobes are ignored. After release, a full run is needed to lock.
- R7: With mute_en = 1, rf_en is high only when lock_det is high and pwr_dn is low.
- R8: With mute_en = 0, rf_en equals the inverse of pwr_dn, with no clock delay. pwr_dn high always forces rf_en low.
- R9: While rst_n is low, lock_det is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_strobe | input | 1 | One-tick marker at the end of each reference window |
| pfd_up | input | 1 | Phase detector up pulse |
| pfd_dn | input | 1 | Phase detector down pulse |
| prec_sel | input | 1 | Run length select: 0 needs three good windows, 1 needs five |
| pwr_dn | input | 1 | Power-down: clears the detector and disables the RF output |
| mute_en | input | 1 | Hold the RF output off until lock |
| lock_det | output | 1 | Lock flag |
| rf_en | output | 1 | Gated RF output enable |

## Verification
Some rules are checked by assertions on every cycle:
- power-down clears the flag and the run;
- a bad window drops lock on the next edge;
- lock rises only after a good window, with the run exactly at the target selected in that cycle;
- the run never exceeds the longer target;
- rf_en obeys the mute and power-down gating.

Other behaviour only the bench scenarios can show. This covers the exact pulse-width boundary between three and four ticks and the number of windows before lock at each precision. It also covers recovery after a broken run or a power-down, and long locked stretches that would expose wraparound.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
    // Result of one reference window, valid for one tick at the strobe
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_GOOD = 2'd1,
        EV_BAD  = 2'd2
    } eval_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/lockdet_width_meter.sv
module lockdet_width_meter
    import lockdet_pkg::*;
#(
    parameter int CLK_PS  = 4000,
    parameter int ERR_PS  = 15000,
    parameter int WIDTH_W = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  pfd_up,
    input  logic  pfd_dn,
    input  logic  ref_strobe,
    output eval_e eval
);
    // smallest tick count whose duration reaches the error limit
    localparam int                 LIMIT   = ceil_div(ERR_PS, CLK_PS);
    localparam logic [WIDTH_W-1:0] LIMIT_V = LIMIT[WIDTH_W-1:0];
    localparam logic [WIDTH_W-1:0] WMAX    = '1;

    typedef struct packed {
        logic [WIDTH_W-1:0] ticks;
    } meter_s;

    meter_s             st_d, st_q;
    logic [WIDTH_W-1:0] sum;
    logic               active;

    always_comb begin
        active = pfd_up | pfd_dn;
        sum    = (active && st_q.ticks != WMAX) ? st_q.ticks + 1'b1 : st_q.ticks;
        st_d   = st_q;
        eval   = EV_NONE;
        if (clr) begin
            st_d.ticks = '0;
        end else if (ref_strobe) begin
            eval       = (sum < LIMIT_V) ? EV_GOOD : EV_BAD;
            st_d.ticks = '0;
        end else begin
            st_d.ticks = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lockdet_streak.sv
module lockdet_streak
    import lockdet_pkg::*;
#(
    parameter int STREAK_W = 3,
    parameter int SHORT_N  = 3,
    parameter int LONG_N   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                prec_sel,
    input  eval_e               eval,
    output logic                lock,
    output logic [STREAK_W-1:0] streak,
    output logic [STREAK_W-1:0] target
);
    localparam logic [STREAK_W-1:0] SHORT_V = SHORT_N[STREAK_W-1:0];
    localparam logic [STREAK_W-1:0] LONG_V  = LONG_N[STREAK_W-1:0];

    typedef struct packed {
        logic [STREAK_W-1:0] cnt;
        logic                lock;
    } streak_s;

    streak_s st_d, st_q;

    always_comb begin
        target = prec_sel ? LONG_V : SHORT_V;
        st_d   = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            case (eval)
                EV_GOOD: begin
                    st_d.cnt  = (st_q.cnt >= target) ? target : st_q.cnt + 1'b1;
                    st_d.lock = (st_d.cnt >= target);
                end
                EV_BAD:  st_d = '0;
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock   = st_q.lock;
    assign streak = st_q.cnt;
endmodule

// File: rtl/lockdet_rf_gate.sv
module lockdet_rf_gate (
    input  logic pwr_dn,
    input  logic mute_en,
    input  logic lock,
    output logic rf_en
);
    always_comb begin
        rf_en = ~pwr_dn & (~mute_en | lock);
    end
endmodule

// File: rtl/lockdet_top.sv
module lockdet_top
    import lockdet_pkg::*;
#(
    parameter int CLK_PS  = 4000,
    parameter int ERR_PS  = 15000,
    parameter int WIDTH_W = 8,
    parameter int SHORT_N = 3,
    parameter int LONG_N  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_strobe,
    input  logic pfd_up,
    input  logic pfd_dn,
    input  logic prec_sel,
    input  logic pwr_dn,
    input  logic mute_en,
    output logic lock_det,
    output logic rf_en
);
    localparam int STREAK_W = $clog2(LONG_N + 1);

    eval_e               eval_w;
    logic [STREAK_W-1:0] streak_w;
    logic [STREAK_W-1:0] target_w;

    lockdet_width_meter #(
        .CLK_PS (CLK_PS),
        .ERR_PS (ERR_PS),
        .WIDTH_W(WIDTH_W)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pwr_dn),
        .pfd_up    (pfd_up),
        .pfd_dn    (pfd_dn),
        .ref_strobe(ref_strobe),
        .eval      (eval_w)
    );

    lockdet_streak #(
        .STREAK_W(STREAK_W),
        .SHORT_N (SHORT_N),
        .LONG_N  (LONG_N)
    ) u_streak (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pwr_dn),
        .prec_sel(prec_sel),
        .eval    (eval_w),
        .lock    (lock_det),
        .streak  (streak_w),
        .target  (target_w)
    );

    lockdet_rf_gate u_gate (
        .pwr_dn (pwr_dn),
        .mute_en(mute_en),
        .lock   (lock_det),
        .rf_en  (rf_en)
    );
endmodule

// File: rtl/lockdet_checker.sv
module lockdet_checker
    import lockdet_pkg::*;
#(
    parameter int STREAK_W = 3,
    parameter int SHORT_N  = 3,
    parameter int LONG_N   = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pwr_dn,
    input logic                mute_en,
    input logic                prec_sel,
    input logic                lock_det,
    input logic                rf_en,
    input eval_e               eval,
    input logic [STREAK_W-1:0] streak
);
    localparam logic [STREAK_W-1:0] SHORT_V = SHORT_N[STREAK_W-1:0];
    localparam logic [STREAK_W-1:0] LONG_V  = LONG_N[STREAK_W-1:0];

    AST_PD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!lock_det && streak == '0)); // R6
    AST_BAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (eval == EV_BAD && !pwr_dn) |=> !lock_det); // R4
    AST_RISE_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_det) |-> $past(eval == EV_GOOD)); // R2
    AST_RISE_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_det) |-> (streak == ($past(prec_sel) ? LONG_V : SHORT_V))); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        streak <= LONG_V); // R5
    AST_MUTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_en && !lock_det) |-> !rf_en); // R7
    AST_UNMUTED_FOLLOWS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_en |-> (rf_en == !pwr_dn)); // R8
endmodule

bind lockdet_top lockdet_checker #(
    .STREAK_W(STREAK_W),
    .SHORT_N (SHORT_N),
    .LONG_N  (LONG_N)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_dn  (pwr_dn),
    .mute_en (mute_en),
    .prec_sel(prec_sel),
    .lock_det(lock_det),
    .rf_en   (rf_en),
    .eval    (eval_w),
    .streak  (streak_w)
);

// File: tb/sim_lockdet_top.sv
`timescale 1ns/1ps
module sim_lockdet_top;
    localparam int CLK_PS = 4000;
    localparam int ERR_PS = 15000;
    localparam int WIN    = 10;

    typedef struct {
        logic  lock;
        logic  rf;
        string req;
    } exp_s;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_strobe = 1'b0, pfd_up = 1'b0, pfd_dn = 1'b0;
    logic prec_sel = 1'b0, pwr_dn = 1'b0, mute_en = 1'b1;
    logic lock_det, rf_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_s sb[$];

    // bench model of the requirements
    int m_cnt = 0;
    bit m_lock = 0;

    always #2 clk = ~clk;

    lockdet_top u0 (
        .clk(clk), .rst_n(rst_n), .ref_strobe(ref_strobe),
        .pfd_up(pfd_up), .pfd_dn(pfd_dn), .prec_sel(prec_sel),
        .pwr_dn(pwr_dn), .mute_en(mute_en),
        .lock_det(lock_det), .rf_en(rf_en)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    function automatic bit exp_rf();
        return !pwr_dn && (!mute_en || m_lock);
    endfunction

    // one reference window with a pulse w ticks wide on up or down
    task automatic window(input int w, input bit use_dn, input string req);
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            pfd_up     = !use_dn && (i < w);
            pfd_dn     =  use_dn && (i < w);
            ref_strobe = (i == WIN - 1);
            if (i == WIN - 1) begin
                int tgt;
                exp_s e;
                tgt = prec_sel ? 5 : 3;
                if (pwr_dn) begin
                    m_cnt = 0; m_lock = 0;
                end else if (w * CLK_PS < ERR_PS) begin      // R1
                    m_cnt  = (m_cnt >= tgt) ? tgt : m_cnt + 1; // R5
                    m_lock = (m_cnt >= tgt);                   // R2 R3
                end else begin
                    m_cnt = 0; m_lock = 0;                     // R4
                end
                e.lock = m_lock;
                e.rf   = exp_rf();
                e.req  = req;
                sb.push_back(e);
            end
        end
        @(negedge clk);
        ref_strobe = 1'b0;
        pfd_up = 1'b0;
        pfd_dn = 1'b0;
    endtask

    task automatic windows(input int n, input int w, input string req);
        for (int k = 0; k < n; k++) window(w, k[0], req);
    endtask

    // monitor: pops one expected item per sampled strobe
    initial begin
        forever begin
            @(posedge clk);
            if (ref_strobe === 1'b1) begin
                #1;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard: strobe without expected item, actual %b expected none", lock_det);
                end else begin
                    exp_s e;
                    e = sb.pop_front();
                    check(e.req, "lock_det", lock_det, e.lock);
                    check(e.req, "rf_en", rf_en, e.rf);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", "lock in reset", lock_det, 1'b0);
        check("R7", "rf muted in reset", rf_en, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: three good windows, boundary width 3 qualifies (R1)
        prec_sel = 1'b0;
        windows(3, 3, "R2");
        @(negedge clk);
        check("R7", "rf on when locked", rf_en, 1'b1);
        // R5: stay locked, no wrap
        windows(12, 1, "R5");
        // R4 and R1: width 4 fails and drops lock
        window(4, 1'b0, "R4");
        window(0, 1'b1, "R4");
        window(2, 1'b0, "R4");
        window(3, 1'b1, "R4");

        // R3: five needed; break at four, then complete
        prec_sel = 1'b1;
        window(9, 1'b0, "R4");
        windows(4, 2, "R3");
        window(6, 1'b1, "R4");
        windows(5, 0, "R3");
        windows(8, 3, "R5");

        // R6: power-down while locked
        @(negedge clk);
        pwr_dn = 1'b1;
        @(negedge clk);
        check("R6", "lock cleared by pwr_dn", lock_det, 1'b0);
        check("R8", "rf off in pwr_dn", rf_en, 1'b0);
        windows(2, 1, "R6");
        pwr_dn = 1'b0;
        windows(5, 1, "R6");

        // R8: mute off, unlocked, enable follows power state
        window(5, 1'b0, "R4");
        mute_en = 1'b0;
        @(negedge clk);
        check("R8", "rf on unmuted unlocked", rf_en, 1'b1);
        pwr_dn = 1'b1;
        #1;
        check("R8", "rf off same cycle pwr_dn", rf_en, 1'b0);
        window(1, 1'b0, "R6");
        pwr_dn = 1'b0;
        #1;
        check("R8", "rf back after pwr_dn", rf_en, 1'b1);
        prec_sel = 1'b0;
        windows(3, 2, "R8");
        mute_en = 1'b1;
        #1;
        check("R7", "rf on muted locked", rf_en, 1'b1);

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule